// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block connects a simple internal request/response bus to an external asynchronous static memory or parallel display controller. It claims one 256 MB address window, splits it into four 64 MB sub-banks with their own active-low chip selects, and turns each internal byte address into the word address that the attached device expects. Both 8-bit and 16-bit devices are supported. A request that is wider than the device is carried out as a run of back-to-back device cycles, with the device address stepping by one per cycle.

Each device cycle has three phases: address setup, data strobe, and address hold. Their lengths in clock cycles come from configuration inputs, and the same timing serves reads and writes. The requester raises `req_valid` and holds the request steady until `rsp_ready` pulses. The configuration is sampled only when a request is accepted. The external data bus appears as separate output, output-enable and input vectors, so the bidirectional pad can sit outside this block.

Top module: `smem_bridge`

## Requirements
- R1: A request whose address bits [31:28] equal 4'h6 is served. Any other address gets `rsp_ready` together with `rsp_err` in the first cycle after acceptance, with no chip select, no strobe and no bus drive. `rsp_err` is low on served requests.
- R2: Address bits [27:26] select the sub-bank: value n drives `mem_cs_n[n]` low for the whole device cycle. The other three chip selects stay high, and at most one chip select is ever low.
- R3: With an 8-bit device (`cfg_wide`=0), device cycle k drives `mem_addr` = byte address [25:0] + k. Data travels on bits [7:0], and a write drives bits [15:8] as zero.
- R4: With a 16-bit device (`cfg_wide`=1), device cycle k drives `mem_addr` = {0, byte address [25:1] + k}, using the full 16-bit data bus. A byte request on a 16-bit device makes one cycle: a write drives the byte on both halves, and a read returns bits [15:8] when address bit 0 is 1 and bits [7:0] otherwise.
- R5: The request size is coded as 0 for a byte, 1 for a halfword and 2 or 3 for a word. The number of device cycles is the request size in bytes divided by the device width in bytes, and at least 1. Cycle k carries data bits [k*W +: W], where W is the device width, so the lowest part comes first. Response data bits above the request size are zero.
- R6: Each device cycle opens with `cfg_addset`+1 cycles in which chip select and address are valid and both strobes are high.
- R7: Next, `mem_we_n` (write) or `mem_oe_n` (read) is low for `cfg_datast`+1 cycles. The two strobes are never low together, and address and write data do not change while a strobe is low.
- R8: After the strobe rises, chip select, address and write data stay unchanged for `cfg_addhold` cycles (0 allowed) before the next device cycle or the end of the request.
- R9: During a read, `mem_dout_en` stays low. Read data is taken from `mem_din` in the last cycle of the strobe phase.
- R10: The device width and the three timing values are sampled when a request is accepted. Changing them during a request has no effect on that request.
- R11: `rsp_ready` is a one-cycle pulse in the cycle after the final device cycle. In that cycle all chip selects and strobes are high. After reset, chip selects and strobes are high, the bus is not driven and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until `rsp_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, least significant part first |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Address outside the window (valid with `rsp_ready`) |
| rsp_rdata | output | 32 | Read data (valid with `rsp_ready`) |
| cfg_wide | input | 1 | Device width: 0 = 8-bit, 1 = 16-bit |
| cfg_addset | input | 4 | Address setup length minus one |
| cfg_datast | input | 8 | Strobe length minus one |
| cfg_addhold | input | 4 | Address hold length |
| mem_addr | output | 26 | Device word address |
| mem_cs_n | output | 4 | Active-low sub-bank chip selects |
| mem_oe_n | output | 1 | Active-low output enable (read strobe) |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | 16 | Data toward the device |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 16 | Data from the device |

## Verification
Several rules are checked on every cycle: at most one chip select low, the two strobes never low together, no bus drive during a read strobe, a strobe only inside a chip select, address and write data frozen while write-enable is low, quiet outputs and a single pulse when the response is given, and error responses that were never preceded by a chip select. Some behaviour only the directed scenarios can show: exact phase lengths for a given configuration, the device address and data lane of each split cycle, the order in which halves are gathered into the read data, that capture happens in the last strobe cycle and not earlier, and that a configuration change in the middle of a request is ignored. The bench's device model returns valid data only in the final strobe cycle.

// File: rtl/smem_pkg.sv
package smem_pkg;

  parameter int SM_ADDR_W = 32;
  parameter int SM_DATA_W = 32;
  parameter int SM_MEM_AW = 26;
  parameter int SM_MEM_DW = 16;
  parameter int SM_BEAT_W = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_DATA,
    PH_HOLD,
    PH_RESP
  } phase_e;

  // Number of device cycles for one request.
  function automatic logic [SM_BEAT_W:0] beat_total(input logic [1:0] size,
                                                    input logic       wide);
    logic [SM_BEAT_W:0] n;
    case (size)
      2'd0:    n = 3'd1;
      2'd1:    n = wide ? 3'd1 : 3'd2;
      default: n = wide ? 3'd2 : 3'd4;
    endcase
    return n;
  endfunction

  // Device word address for beat number 'beat'.
  function automatic logic [SM_MEM_AW-1:0] dev_word_addr(
      input logic [SM_MEM_AW-1:0] byte_addr,
      input logic                 wide,
      input logic [SM_BEAT_W-1:0] beat);
    logic [SM_MEM_AW-1:0] base;
    logic [SM_MEM_AW-1:0] sum;
    base = wide ? (byte_addr >> 1) : byte_addr;
    sum  = base + SM_MEM_AW'(beat);
    if (wide) sum[SM_MEM_AW-1] = 1'b0;
    return sum;
  endfunction

  // Value placed on the device data bus for one write beat.
  function automatic logic [SM_MEM_DW-1:0] write_lane(
      input logic [SM_DATA_W-1:0] wdata,
      input logic [1:0]           size,
      input logic                 wide,
      input logic [SM_BEAT_W-1:0] beat);
    logic [SM_MEM_DW-1:0] v;
    if (!wide)
      v = {8'h00, wdata[{beat, 3'b000} +: 8]};
    else if (size == 2'd0)
      v = {wdata[7:0], wdata[7:0]};
    else
      v = wdata[{beat[0], 4'b0000} +: 16];
    return v;
  endfunction

  // Merge one captured device word into the response word.
  function automatic logic [SM_DATA_W-1:0] read_merge(
      input logic [SM_DATA_W-1:0] cur,
      input logic [SM_MEM_DW-1:0] din,
      input logic [1:0]           size,
      input logic                 wide,
      input logic                 odd,
      input logic [SM_BEAT_W-1:0] beat);
    logic [SM_DATA_W-1:0] v;
    v = cur;
    if (!wide)
      v[{beat, 3'b000} +: 8] = din[7:0];
    else if (size == 2'd0)
      v[7:0] = odd ? din[15:8] : din[7:0];
    else
      v[{beat[0], 4'b0000} +: 16] = din;
    return v;
  endfunction

endpackage

// File: rtl/smem_decode.sv
module smem_decode #(
  parameter int ADDR_W = 32,
  parameter int MEM_AW = 26,
  parameter int BANK_W = 2,
  parameter logic [ADDR_W-MEM_AW-BANK_W-1:0] WIN_TAG = 'h6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [BANK_W-1:0] bank
);
  localparam int TAG_LSB = MEM_AW + BANK_W;

  assign hit  = (addr[ADDR_W-1:TAG_LSB] == WIN_TAG);
  assign bank = addr[TAG_LSB-1:MEM_AW];
endmodule

// File: rtl/smem_seq.sv
module smem_seq
  import smem_pkg::*;
#(
  parameter int ASET_W = 4,
  parameter int DSET_W = 8,
  parameter int AHLD_W = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              reject,
  input  logic [ASET_W-1:0] addset,
  input  logic [DSET_W-1:0] datast,
  input  logic [AHLD_W-1:0] addhold,
  input  logic [BEAT_W:0]   nbeats,
  output phase_e            phase,
  output logic [BEAT_W-1:0] beat,
  output logic              capture,
  output logic              beat_end,
  output logic              last_beat
);
  localparam int MAX_AD = (ASET_W > DSET_W) ? ASET_W : DSET_W;
  localparam int CNT_W  = (MAX_AD > AHLD_W) ? MAX_AD : AHLD_W;

  logic [CNT_W-1:0]  cnt;
  logic [ASET_W-1:0] aset_q;
  logic [DSET_W-1:0] dset_q;
  logic [AHLD_W-1:0] ahld_q;
  logic [BEAT_W:0]   nb_q;

  assign capture   = (phase == PH_DATA) && (cnt == '0);
  assign beat_end  = (capture && (ahld_q == '0)) ||
                     ((phase == PH_HOLD) && (cnt == '0));
  assign last_beat = ((BEAT_W+1)'(beat) + 1'b1) == nb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      beat   <= '0;
      aset_q <= '0;
      dset_q <= '0;
      ahld_q <= '0;
      nb_q   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (go) begin
            phase  <= PH_SETUP;
            cnt    <= CNT_W'(addset);
            beat   <= '0;
            aset_q <= addset;
            dset_q <= datast;
            ahld_q <= addhold;
            nb_q   <= nbeats;
          end else if (reject) begin
            phase <= PH_RESP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_DATA;
            cnt   <= CNT_W'(dset_q);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_DATA, PH_HOLD: begin
          if (beat_end) begin
            if (last_beat) begin
              phase <= PH_RESP;
            end else begin
              phase <= PH_SETUP;
              beat  <= beat + 1'b1;
              cnt   <= CNT_W'(aset_q);
            end
          end else if (capture) begin
            phase <= PH_HOLD;
            cnt   <= CNT_W'(ahld_q - 1'b1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smem_bridge.sv
module smem_bridge
  import smem_pkg::*;
#(
  parameter int ADDR_W = SM_ADDR_W,
  parameter int DATA_W = SM_DATA_W,
  parameter int MEM_AW = SM_MEM_AW,
  parameter int MEM_DW = SM_MEM_DW,
  parameter int NBANK  = 4,
  parameter int ASET_W = 4,
  parameter int DSET_W = 8,
  parameter int AHLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ready,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cfg_wide,
  input  logic [ASET_W-1:0] cfg_addset,
  input  logic [DSET_W-1:0] cfg_datast,
  input  logic [AHLD_W-1:0] cfg_addhold,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [NBANK-1:0]  mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [MEM_DW-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [MEM_DW-1:0] mem_din
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int BEAT_W = SM_BEAT_W;

  // Named internal events (also observed by the checker)
  phase_e            phase;
  logic [BEAT_W-1:0] beat;
  logic              capture;
  logic              beat_end;
  logic              last_beat;
  logic              accept;
  logic              win_hit;
  logic [BANK_W-1:0] win_bank;
  logic              in_beat;
  logic              strobe;

  // Request state captured on acceptance
  logic              wr_q;
  logic [1:0]        size_q;
  logic [MEM_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wide_q;
  logic [BANK_W-1:0] bank_q;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;

  smem_decode #(
    .ADDR_W (ADDR_W),
    .MEM_AW (MEM_AW),
    .BANK_W (BANK_W)
  ) u_decode (
    .addr (req_addr),
    .hit  (win_hit),
    .bank (win_bank)
  );

  assign accept = req_valid && (phase == PH_IDLE);

  smem_seq #(
    .ASET_W (ASET_W),
    .DSET_W (DSET_W),
    .AHLD_W (AHLD_W),
    .BEAT_W (BEAT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (accept && win_hit),
    .reject    (accept && !win_hit),
    .addset    (cfg_addset),
    .datast    (cfg_datast),
    .addhold   (cfg_addhold),
    .nbeats    (beat_total(req_size, cfg_wide)),
    .phase     (phase),
    .beat      (beat),
    .capture   (capture),
    .beat_end  (beat_end),
    .last_beat (last_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wide_q  <= 1'b0;
      bank_q  <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        wr_q    <= req_write;
        size_q  <= req_size;
        addr_q  <= req_addr[MEM_AW-1:0];
        wdata_q <= req_wdata;
        wide_q  <= cfg_wide;
        bank_q  <= win_bank;
        err_q   <= !win_hit;
        rdata_q <= '0;
      end else if (capture && !wr_q) begin
        rdata_q <= read_merge(rdata_q, mem_din, size_q, wide_q, addr_q[0], beat);
      end
    end
  end

  assign in_beat = (phase == PH_SETUP) || (phase == PH_DATA) || (phase == PH_HOLD);
  assign strobe  = (phase == PH_DATA);

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_cs
    assign mem_cs_n[gi] = !(in_beat && (bank_q == BANK_W'(gi)));
  end

  assign mem_we_n    = !(strobe && wr_q);
  assign mem_oe_n    = !(strobe && !wr_q);
  assign mem_addr    = dev_word_addr(addr_q, wide_q, beat);
  assign mem_dout_en = in_beat && wr_q;
  assign mem_dout    = mem_dout_en ? write_lane(wdata_q, size_q, wide_q, beat) : '0;

  assign rsp_ready = (phase == PH_RESP);
  assign rsp_err   = (phase == PH_RESP) && err_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/smem_bridge_chk.sv
module smem_bridge_chk #(
  parameter int MEM_AW = 26,
  parameter int MEM_DW = 16,
  parameter int NBANK  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_ready,
  input logic              rsp_err,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [NBANK-1:0]  mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [MEM_DW-1:0] mem_dout,
  input logic              mem_dout_en,
  input logic              capture,
  input logic              beat_end,
  input logic              last_beat
);
  p_single_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1);

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  p_strobe_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

  p_we_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

  p_read_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dout_en);

  p_capture_in_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !mem_dout_en) |-> !mem_oe_n);

  p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (&mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en));

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  p_err_no_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && rsp_err) |-> $past(&mem_cs_n));

  p_err_with_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_ready);

  p_ready_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !rsp_err) |-> $past(beat_end && last_beat));
endmodule

bind smem_bridge smem_bridge_chk #(
  .MEM_AW (MEM_AW),
  .MEM_DW (MEM_DW),
  .NBANK  (NBANK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rsp_ready   (rsp_ready),
  .rsp_err     (rsp_err),
  .mem_addr    (mem_addr),
  .mem_cs_n    (mem_cs_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_dout    (mem_dout),
  .mem_dout_en (mem_dout_en),
  .capture     (capture),
  .beat_end    (beat_end),
  .last_beat   (last_beat)
);

// File: tb/sim_smem_bridge.sv
`timescale 1ns/1ps
module sim_smem_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = 32'h0;
  logic [31:0] req_wdata = 32'h0;
  logic        rsp_ready;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        cfg_wide = 1'b0;
  logic [3:0]  cfg_addset = 4'd0;
  logic [7:0]  cfg_datast = 8'd0;
  logic [3:0]  cfg_addhold = 4'd0;
  logic [25:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [15:0] mem_dout;
  logic        mem_dout_en;
  logic [15:0] mem_din;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int oe_run = 0;
  int cur_d  = 0;

  always #10 clk = ~clk;

  smem_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_wide(cfg_wide), .cfg_addset(cfg_addset), .cfg_datast(cfg_datast),
    .cfg_addhold(cfg_addhold),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din)
  );

  // Device model: content depends on the address; valid only in the final strobe cycle.
  function automatic logic [15:0] pat(input logic [25:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  always @(negedge clk) begin
    if (!mem_oe_n) oe_run <= oe_run + 1;
    else           oe_run <= 0;
  end

  assign mem_din = (!mem_oe_n && (oe_run == cur_d + 1)) ? pat(mem_addr) : 16'hBAD0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int exp_beats(input logic [1:0] sz, input bit wide);
    int bytes;
    int n;
    bytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    n = wide ? bytes / 2 : bytes;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic logic [25:0] exp_addr(input logic [31:0] a, input bit wide, input int k);
    logic [31:0] t;
    if (wide) begin
      t = ((a & 32'h03FF_FFFF) >> 1) + k;
      return t[25:0] & 26'h1FF_FFFF;
    end
    t = a + k;
    return t[25:0];
  endfunction

  function automatic logic [15:0] exp_dout(input logic [31:0] wd, input logic [1:0] sz,
                                           input bit wide, input int k);
    logic [31:0] t;
    if (!wide) begin
      t = (wd >> (8 * k)) & 32'hFF;
      return t[15:0];
    end
    if (sz == 2'd0) return {wd[7:0], wd[7:0]};
    t = (wd >> (16 * k)) & 32'hFFFF;
    return t[15:0];
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [31:0] a, input logic [1:0] sz,
                                            input bit wide);
    logic [31:0] r;
    logic [15:0] p;
    r = 32'h0;
    for (int k = 0; k < exp_beats(sz, wide); k++) begin
      p = pat(exp_addr(a, wide, k));
      if (!wide)           r = r | ({24'h0, p[7:0]} << (8 * k));
      else if (sz == 2'd0) r = a[0] ? {24'h0, p[15:8]} : {24'h0, p[7:0]};
      else                 r = r | ({16'h0, p} << (16 * k));
    end
    return r;
  endfunction

  // One request: compares every cycle of the bus against the expected trace.
  task automatic do_access(input string tag, input bit wr, input logic [1:0] sz,
                           input logic [31:0] ad, input logic [31:0] wd, input bit wide,
                           input int a, input int d, input int h, input bit chg);
    int nb, len, i;
    bit got, err_exp;
    bit bad_cs, bad_su, bad_dt, bad_hd, bad_ad, bad_do, bad_en;
    logic [31:0] act_cs, exp_cs, act_su, act_dt, exp_dt, act_hd, act_ad, exp_ad;
    logic [31:0] act_do, exp_do;
    string areq;
    err_exp = (ad[31:28] != 4'h6);
    nb  = err_exp ? 0 : exp_beats(sz, wide);
    len = a + d + h + 2;
    areq = wide ? "R4" : "R3";
    {bad_cs, bad_su, bad_dt, bad_hd, bad_ad, bad_do, bad_en} = '0;
    {act_cs, exp_cs, act_su, act_dt, exp_dt, act_hd, act_ad, exp_ad, act_do, exp_do} = '0;
    cfg_wide = wide; cfg_addset = 4'(a); cfg_datast = 8'(d); cfg_addhold = 4'(h);
    cur_d = d;
    req_write = wr; req_size = sz; req_addr = ad; req_wdata = wd; req_valid = 1'b1;
    i = 0; got = 1'b0;
    for (int guard = 0; guard < 3000 && !got; guard++) begin
      @(negedge clk);
      if (rsp_ready) begin
        got = 1'b1;
      end else begin
        int k, p;
        logic [3:0] ecs;
        logic [1:0] stb;
        k = i / len;
        p = i % len;
        ecs = ~(4'b0001 << ad[27:26]);
        stb = {mem_we_n, mem_oe_n};
        if (mem_cs_n != ecs && !bad_cs) begin bad_cs = 1; act_cs = 32'(mem_cs_n); exp_cs = 32'(ecs); end
        if (p <= a) begin
          if (stb != 2'b11 && !bad_su) begin bad_su = 1; act_su = 32'(stb); end
        end else if (p <= a + d + 1) begin
          logic [1:0] es;
          es = wr ? 2'b01 : 2'b10;
          if (stb != es && !bad_dt) begin bad_dt = 1; act_dt = 32'(stb); exp_dt = 32'(es); end
        end else begin
          if (stb != 2'b11 && !bad_hd) begin bad_hd = 1; act_hd = 32'(stb); end
        end
        if (mem_addr != exp_addr(ad, wide, k) && !bad_ad) begin
          bad_ad = 1; act_ad = 32'(mem_addr); exp_ad = 32'(exp_addr(ad, wide, k));
        end
        if (mem_dout_en != wr) bad_en = 1;
        if (wr && mem_dout != exp_dout(wd, sz, wide, k) && !bad_do) begin
          bad_do = 1; act_do = 32'(mem_dout); exp_do = 32'(exp_dout(wd, sz, wide, k));
        end
        i++;
      end
      if (chg && i == 1) begin
        cfg_addset = 4'd7; cfg_datast = 8'd9; cfg_addhold = 4'd5; cfg_wide = !wide;
      end
    end
    req_valid = 1'b0;
    chk(got, "R11", {tag, " response arrives"}, 32'(got), 32'd1);
    chk(i == nb * len, "R5", {tag, " bus cycles before ready"}, 32'(i), 32'(nb * len));
    chk(rsp_err == err_exp, "R1", {tag, " error flag"}, 32'(rsp_err), 32'(err_exp));
    if (nb > 0) begin
      chk(!bad_cs, "R2", {tag, " chip select"}, act_cs, exp_cs);
      chk(!bad_su, "R6", {tag, " setup strobes high"}, act_su, 32'h3);
      chk(!bad_dt, "R7", {tag, " strobe phase"}, act_dt, exp_dt);
      chk(!bad_hd, "R8", {tag, " hold strobes high"}, act_hd, 32'h3);
      chk(!bad_ad, areq, {tag, " device address"}, act_ad, exp_ad);
      chk(!bad_en, "R9", {tag, " bus drive matches direction"}, 32'(bad_en), 32'h0);
      if (wr)
        chk(!bad_do, areq, {tag, " write lane"}, act_do, exp_do);
      else
        chk(rsp_rdata == exp_rdata(ad, sz, wide), "R9", {tag, " read data"},
            rsp_rdata, exp_rdata(ad, sz, wide));
    end
    @(negedge clk);
    chk(!rsp_ready && (&mem_cs_n), "R11", {tag, " ready is one cycle"},
        {27'h0, rsp_ready, mem_cs_n}, 32'h0000000F);
  endtask

  task automatic t_reset;
    chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dout_en && !rsp_ready,
        "R11", "reset state",
        {24'h0, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en, rsp_ready},
        {24'h0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0});
  endtask

  task automatic t_write_split;
    do_access("R3 R5 wr8 word bank0", 1'b1, 2'd2, 32'h6000_0100, 32'hA1B2_C3D4, 1'b0, 1, 2, 0, 1'b0);
    do_access("R4 R5 wr16 word bank2", 1'b1, 2'd2, 32'h6800_0ABC, 32'h1357_9BDF, 1'b1, 0, 3, 0, 1'b0);
  endtask

  task automatic t_read_split;
    do_access("R4 R5 rd16 word bank3", 1'b0, 2'd2, 32'h6C00_0040, 32'h0, 1'b1, 0, 0, 1, 1'b0);
    do_access("R3 R5 rd8 half odd bank2", 1'b0, 2'd1, 32'h6800_0031, 32'h0, 1'b0, 1, 1, 1, 1'b0);
    do_access("R3 rd8 word window top", 1'b0, 2'd2, 32'h6FFF_FFFC, 32'h0, 1'b0, 3, 4, 2, 1'b0);
  endtask

  task automatic t_hold_phase;
    do_access("R8 wr16 half bank1", 1'b1, 2'd1, 32'h6400_0012, 32'h0000_BEEF, 1'b1, 2, 1, 2, 1'b0);
  endtask

  task automatic t_byte_on_wide;
    do_access("R4 rd16 byte odd", 1'b0, 2'd0, 32'h6000_0203, 32'h0, 1'b1, 0, 1, 0, 1'b0);
    do_access("R4 rd16 byte even", 1'b0, 2'd0, 32'h6000_0202, 32'h0, 1'b1, 0, 1, 0, 1'b0);
    do_access("R4 wr16 byte", 1'b1, 2'd0, 32'h6400_0005, 32'h0000_0077, 1'b1, 1, 0, 1, 1'b0);
  endtask

  task automatic t_out_of_window;
    do_access("R1 above window", 1'b0, 2'd2, 32'h7000_0000, 32'h0, 1'b1, 1, 1, 1, 1'b0);
    do_access("R1 below window", 1'b1, 2'd2, 32'h5FFF_FFFC, 32'hFFFF_FFFF, 1'b0, 1, 1, 1, 1'b0);
    do_access("R1 far window", 1'b0, 2'd1, 32'hE000_0000, 32'h0, 1'b0, 0, 0, 0, 1'b0);
  endtask

  task automatic t_cfg_change;
    do_access("R10 cfg change rd16 word", 1'b0, 2'd2, 32'h6400_0100, 32'h0, 1'b1, 1, 2, 1, 1'b1);
    do_access("R10 cfg change wr8 half", 1'b1, 2'd1, 32'h6000_0777, 32'h0000_5AA5, 1'b0, 0, 1, 1, 1'b1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_split();
    t_read_split();
    t_hold_phase();
    t_byte_on_wide();
    t_out_of_window();
    t_cfg_change();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule